// File: doc/BRIEF.md
# Two-Tier Address-Decoded Wait-State Generator

This block turns a fast oscillator into a processor clock whose bus cycle length depends on where the processor is pointing. Every bus cycle is built from units of four oscillator ticks. Two tiers of counters repeat that unit. A coarse tier looks only at the two top address bits, so it can start stretching before full decode has settled. A fine tier checks a 2 KB-granular lookup table and an external slow request, and it decides later in the cycle.

Each tier either leaves the cycle alone or multiplies it by three. A cycle therefore lasts 4, 12 or 36 oscillator ticks. The number of units per cycle is always odd (1, 3 or 9). The processor clock phase is low for the first half of a cycle and high for the second half. A one-tick strobe marks the last tick of every cycle, so the surrounding logic can present the next address.

Top module: `wait_state_gen`

## Requirements
- R1: While reset is held low, `phi2` and `cyc_done` are both 0.
- R2: When neither tier stretches, a bus cycle lasts exactly 4 oscillator ticks.
- R3: The coarse tier multiplies the cycle by 3 when address bits 15 and 14 are both 1 in the tick in which `cyc_done` is high. Any other value of those bits leaves the coarse factor at 1.
- R4: The fine tier multiplies the cycle by 3 when the address in the tick after `cyc_done` falls in 0xC000–0xC7FF or 0xE000–0xFFFF. Together with R3, these regions give 36-tick cycles.
- R5: The region 0xC800–0xDFFF is stretched by the coarse tier only, which gives 12-tick cycles.
- R6: `slow_req` high in the tick after `cyc_done` forces the fine factor to 3, even for an address the table marks as fast.
- R7: The coarse factor is fixed by the address in the `cyc_done` tick. The fine factor is fixed by the address and `slow_req` in the next tick. Later changes to either input in the same cycle do not change its length.
- R8: In a cycle of T ticks, `phi2` is 0 for the first T/2 ticks and 1 for the last T/2. `cyc_done` is high only in the last tick, and `phi2` is 1 in that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address, valid early in the cycle |
| slow_req | input | 1 | External request for fine-tier stretching |
| phi2 | output | 1 | Processor clock phase (high in second half of cycle) |
| cyc_done | output | 1 | One-tick strobe on the last tick of each bus cycle |

## Verification
A wrong tier selection or a counter that wraps early shows up as a `cyc_done` interval other than 4, 12 or 36 ticks. A wrong half-cycle constant moves the `phi2` rising edge away from the midpoint. Both appear within the same bus cycle. The bench changes the address in the tick where each tier decides, and again after that tick. A latch point one tick early or late therefore produces a wrong length on the first affected cycle.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    // Per-cycle decision from the two decode tiers.
    typedef struct packed {
        logic coarse_slow;  // top-of-map decode asks for coarse stretch
        logic fine_slow;    // region table or external request asks for fine stretch
    } wsg_class_t;

    // Repeat count of a tier, given whether it stretches.
    function automatic int unsigned tier_reps(input logic stretched, input int unsigned mult);
        return stretched ? mult : 1;
    endfunction

endpackage

// File: rtl/wsg_coarse_decode.sv
module wsg_coarse_decode (
    input  logic [1:0] top_bits,
    output logic       stretch
);
    // Upper quarter of the map starts the preliminary stretch.
    always_comb begin
        stretch = (top_bits == 2'b11);
    end
endmodule

// File: rtl/wsg_fine_decode.sv
module wsg_fine_decode #(
    parameter int unsigned              IDX_W    = 5,
    parameter logic [(2**IDX_W)-1:0]    SLOW_MAP = '0
) (
    input  logic [IDX_W-1:0] region_idx,
    input  logic             ext_req,
    output logic             slow
);
    localparam int unsigned NREG = 2 ** IDX_W;

    logic [NREG-1:0] region_tbl;

    // One table bit per region, fixed at elaboration.
    for (genvar i = 0; i < NREG; i++) begin : g_tbl
        assign region_tbl[i] = SLOW_MAP[i];
    end

    always_comb begin
        slow = region_tbl[region_idx] | ext_req;
    end
endmodule

// File: rtl/wsg_sequencer.sv
module wsg_sequencer
    import wsg_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 4,
    parameter int unsigned FAST_MULT  = 3,
    parameter int unsigned SLOW_MULT  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wsg_class_t cls,
    output logic       phi2,
    output logic       cyc_done
);
    localparam int unsigned MAXM   = (FAST_MULT > SLOW_MULT) ? FAST_MULT : SLOW_MULT;
    localparam int unsigned MW     = $clog2(MAXM + 1);
    localparam int unsigned TW     = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam int unsigned MAXLEN = UNIT_TICKS * FAST_MULT * SLOW_MULT;
    localparam int unsigned EW     = $clog2(MAXLEN + 1);
    localparam int unsigned HALFU  = UNIT_TICKS / 2;

    localparam logic [TW-1:0] TICK_LAST = TW'(UNIT_TICKS - 1);
    localparam logic [MW-1:0] FAST_LAST = MW'(FAST_MULT - 1);
    localparam logic [MW-1:0] SLOW_LAST = MW'(SLOW_MULT - 1);
    localparam logic [EW-1:0] LATCH_AT  = EW'(HALFU - 1);
    localparam logic [EW-1:0] HALF_NN   = EW'(HALFU);
    localparam logic [EW-1:0] HALF_FN   = EW'(HALFU * FAST_MULT);
    localparam logic [EW-1:0] HALF_NS   = EW'(HALFU * SLOW_MULT);
    localparam logic [EW-1:0] HALF_FS   = EW'(HALFU * FAST_MULT * SLOW_MULT);

    typedef struct packed {
        logic [TW-1:0] tick;     // position inside a unit
        logic [MW-1:0] frep;     // coarse-tier repeat index
        logic [MW-1:0] srep;     // fine-tier repeat index
        logic [EW-1:0] elapsed;  // ticks since cycle start
        logic          pf;       // coarse stretch in force
        logic          ps;       // fine stretch in force
        logic          phi2;
        logic          done;
        logic          started;  // a full cycle has been seen since reset
    } seq_t;

    seq_t q, d;

    logic          first_tick, latch_tick;
    logic          pf_eff, ps_eff;
    logic [MW-1:0] f_last, s_last;
    logic [EW-1:0] half;
    logic          unit_end, f_end, s_end, last;

    always_comb begin
        d = q;

        first_tick = (q.elapsed == '0);
        latch_tick = (q.elapsed == LATCH_AT);

        // Coarse tier decides in the first tick, fine tier at the end of the first fast phase.
        pf_eff = first_tick ? cls.coarse_slow : q.pf;
        ps_eff = latch_tick ? cls.fine_slow   : q.ps;

        f_last = pf_eff ? FAST_LAST : '0;
        s_last = ps_eff ? SLOW_LAST : '0;

        unique case ({pf_eff, ps_eff})
            2'b00:   half = HALF_NN;
            2'b10:   half = HALF_FN;
            2'b01:   half = HALF_NS;
            default: half = HALF_FS;
        endcase

        unit_end = (q.tick == TICK_LAST);
        f_end    = (q.frep == f_last);
        s_end    = (q.srep == s_last);
        last     = unit_end && f_end && s_end;

        d.tick    = unit_end ? '0 : q.tick + 1'b1;
        d.frep    = unit_end ? (f_end ? '0 : q.frep + 1'b1) : q.frep;
        d.srep    = (unit_end && f_end) ? (s_end ? '0 : q.srep + 1'b1) : q.srep;
        d.elapsed = last ? '0 : q.elapsed + 1'b1;
        d.pf      = pf_eff;
        d.ps      = ps_eff;
        d.phi2    = (q.elapsed >= half);
        d.done    = last;
        d.started = q.started | q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign phi2     = q.phi2;
    assign cyc_done = q.done;

    // R8: the strobe lasts one tick.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R8: the last tick of a cycle is in the high phase.
    p_done_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.phi2);

    // R8: a new cycle opens in the low phase.
    p_open_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.phi2);

    // R8: phi2 never rises on the final tick.
    p_rise_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.phi2) |-> !q.done);

    // R2: an unstretched cycle spans exactly one unit between strobes.
    p_fast_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.started && !q.pf && !q.ps) |-> $past(q.done, UNIT_TICKS));

    // R3: the coarse repeat index stays within the selected factor.
    p_frep_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.elapsed != '0 && !q.pf) |-> (q.frep == '0));

endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
    import wsg_pkg::*;
#(
    parameter int unsigned               ADDR_W     = 16,
    parameter int unsigned               REGION_W   = 5,
    parameter int unsigned               UNIT_TICKS = 4,
    parameter int unsigned               FAST_MULT  = 3,
    parameter int unsigned               SLOW_MULT  = 3,
    parameter logic [(2**REGION_W)-1:0]  SLOW_MAP   = 32'hF100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              slow_req,
    output logic              phi2,
    output logic              cyc_done
);
    wsg_class_t cls;

    wsg_coarse_decode u_coarse (
        .top_bits (addr[ADDR_W-1 -: 2]),
        .stretch  (cls.coarse_slow)
    );

    wsg_fine_decode #(
        .IDX_W    (REGION_W),
        .SLOW_MAP (SLOW_MAP)
    ) u_fine (
        .region_idx (addr[ADDR_W-1 -: REGION_W]),
        .ext_req    (slow_req),
        .slow       (cls.fine_slow)
    );

    wsg_sequencer #(
        .UNIT_TICKS (UNIT_TICKS),
        .FAST_MULT  (FAST_MULT),
        .SLOW_MULT  (SLOW_MULT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .phi2     (phi2),
        .cyc_done (cyc_done)
    );
endmodule

// File: tb/sim_wait_state_gen.sv
`timescale 1ns/1ps
module sim_wait_state_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        sreq = 1'b0;
    logic        phi2, done;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    wait_state_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .slow_req (sreq),
        .phi2     (phi2),
        .cyc_done (done)
    );

    always #5 clk = ~clk;

    function automatic bit slow_region(input logic [15:0] a);
        return (a >= 16'hC000 && a <= 16'hC7FF) || (a >= 16'hE000);
    endfunction

    function automatic int exp_len(input logic [15:0] a, input logic [15:0] b, input logic rb);
        int f, s;
        f = (a[15:14] == 2'b11) ? 3 : 1;
        s = (slow_region(b) || rb) ? 3 : 1;
        return 4 * f * s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at the negedge where done is seen: a picks the coarse tier now,
    // b and rb pick the fine tier next tick, c and rc arrive afterwards.
    task automatic run_cycle(input logic [15:0] a, input logic [15:0] b, input logic rb,
                             input logic [15:0] c, input logic rc, input string req);
        int exp, n, phase_bad;
        exp = exp_len(a, b, rb);
        n = 0;
        phase_bad = 0;
        addr = a;
        sreq = rc;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (phi2 !== ((n > exp / 2) ? 1'b1 : 1'b0)) phase_bad++;
            if (n == 1) begin addr = b; sreq = rb; end
            if (n == 2) begin addr = c; sreq = rc; end
            if (done === 1'b1) break;
        end
        check(n == exp, req, n, exp);
        check(phase_bad == 0, "R8 phase", phase_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(phi2 === 1'b0, "R1 phi2", int'(phi2), 0);
        check(done === 1'b0, "R1 done", int'(done), 0);
        rst_n = 1'b1;
        n = 0;
        while (done !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == 4, "R2 first cycle", n, 4);

        run_cycle(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R2");
        run_cycle(16'hBFFF, 16'hBFFF, 1'b0, 16'hBFFF, 1'b0, "R2");
        run_cycle(16'hC000, 16'hC000, 1'b0, 16'hC000, 1'b0, "R4");
        run_cycle(16'hC7FF, 16'hC7FF, 1'b0, 16'hC7FF, 1'b0, "R4");
        run_cycle(16'hE000, 16'hE000, 1'b0, 16'hE000, 1'b0, "R4");
        run_cycle(16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFF, 1'b0, "R4");
        run_cycle(16'hC800, 16'hC800, 1'b0, 16'hC800, 1'b0, "R5");
        run_cycle(16'hDFFF, 16'hDFFF, 1'b0, 16'hDFFF, 1'b0, "R5");
        run_cycle(16'hC000, 16'h4000, 1'b0, 16'h4000, 1'b0, "R3");
        run_cycle(16'h1234, 16'h1234, 1'b1, 16'h1234, 1'b0, "R6");
        run_cycle(16'h0000, 16'hF000, 1'b0, 16'h0000, 1'b0, "R7");
        run_cycle(16'hC000, 16'h0000, 1'b0, 16'hFFFF, 1'b1, "R7");
        run_cycle(16'h0000, 16'h0000, 1'b0, 16'hFFFF, 1'b1, "R7");

        for (int i = 0; i < 300; i++) begin
            logic [15:0] a, b, c;
            logic rb, rc;
            a  = 16'($urandom);
            b  = (i % 3 == 0) ? a : 16'($urandom);
            c  = 16'($urandom);
            rb = ($urandom % 4) == 0;
            rc = 1'($urandom);
            run_cycle(a, b, rb, c, rc, "R7 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule